// File: doc/BRIEF.md
# Potentiometer Dial-to-Channel Mapper

This block turns the two resistance readings of a dial potentiometer, one on each side of the wiper, into a tuning position or a volume setting. The wiper fraction X/(X+Y) is spread linearly over the band plus a guard zone of extra steps at each end. A wiper parked inside a guard zone therefore holds the band edge and does not wrap. This absorbs the mechanical slack near the end stops of a physical dial.

In channel mode the result is a channel index that is snapped to the grid. The block also reports the matching frequency in kHz, built from a band start value, an FM or AM unit and a coded channel spacing. In volume mode the same ratio drives a 5-bit volume code, where each code step is 2 dB. A one-cycle `start` begins a conversion, and a bit-serial divider then runs for a fixed number of cycles. A one-cycle `done` marks the new result. A separate pulse asks the tuner to retune, but only when the channel has actually moved.

Top module: `dial_mapper`

## Requirements
- R1: After reset, `done` and `tune_req` are 0, `chan_idx` is 0, `freq_khz` is 0 and `vol_code` is 31.
- R2: In channel mode (`vol_mode`=0), with S = `chan_count` + 2·`chan_guard`, the raw position is q = floor((2·X·S + X + Y) / (2·(X+Y))), which is X·S/(X+Y) rounded half up. The channel index is then q − `chan_guard`.
- R3: If q < `chan_guard`, the channel index is 0. If q − `chan_guard` > `chan_count`, the channel index is `chan_count`.
- R4: `freq_khz` = base + `chan_idx`·step. The base is `band_start`·50 when `am_band`=0, and `band_start`·1 when `am_band`=1. The `spacing` code gives the step in kHz. For FM: 00→200, 01→100, 10 or 11→50. For AM: 00→1, 01→9, 10 or 11→10.
- R5: In volume mode (`vol_mode`=1), the code is round(X·(32+2·`vol_guard`)/(X+Y)) − `vol_guard`, rounded half up and clamped to 0..31. The level is 2·code − 62 dB. This mode leaves `chan_idx`, `freq_khz` and `tune_req` untouched.
- R6: `done` is a single-cycle pulse. It is first seen high 28 clock edges after the edge that samples `start`, with default parameters. Outside that pulse, every result output holds its value.
- R7: If X+Y = 0 when `start` is sampled, no conversion runs, no `done` appears and every output keeps its value.
- R8: `tune_req` pulses together with a channel-mode `done` exactly when the new channel index differs from the previous one. It never pulses in volume mode.
- R9: A `start` that arrives while a conversion is running is ignored. The result comes only from the inputs sampled at the accepted `start`, and only one `done` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (one cycle) |
| vol_mode | input | 1 | 0 = channel mapping, 1 = volume mapping |
| am_band | input | 1 | 0 = FM units (50 kHz base), 1 = AM units (1 kHz base) |
| meas_x | input | 12 | Resistance on the low side of the wiper |
| meas_y | input | 12 | Resistance on the high side of the wiper |
| chan_count | input | 12 | Number of channel steps in the band |
| band_start | input | 15 | Band bottom in base units |
| spacing | input | 2 | Channel spacing code |
| chan_guard | input | 9 | Guard steps at each end of the channel dial |
| vol_guard | input | 7 | Guard steps (2 dB each) at each end of the volume dial |
| done | output | 1 | New result valid (one cycle) |
| tune_req | output | 1 | Channel moved, request a retune (one cycle) |
| chan_idx | output | 12 | Channel index within the band |
| freq_khz | output | 22 | Tuned frequency in kHz |
| vol_code | output | 5 | Volume code, 31 = 0 dB, 0 = −62 dB |

## Verification
The wiper is placed at the centre, deep inside each guard zone and on exact half-step fractions. The centre case shows whether the guard stretch and offset are right. The guard-zone cases separate a correct clamp from wrap-around or underflow. The half-step fractions separate round-half-up from truncation. The same positions are repeated under every FM and AM spacing code and in volume mode, which exposes a wrong step table, a wrong base unit or a mode that corrupts the other mode's outputs. A zero-sum reading, a repeated identical position and a second start issued mid-conversion each show whether spurious `done` or `tune_req` pulses are suppressed.

// File: rtl/dial_map_pkg.sv
package dial_map_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } map_state_e;

    // channel step in kHz for a band type and a spacing code
    function automatic logic [7:0] step_khz(input logic am, input logic [1:0] code);
        logic [7:0] s;
        if (am) begin
            case (code)
                2'b00:   s = 8'd1;
                2'b01:   s = 8'd9;
                default: s = 8'd10;
            endcase
        end else begin
            case (code)
                2'b00:   s = 8'd200;
                2'b01:   s = 8'd100;
                default: s = 8'd50;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/dial_div.sv
// Restoring divider, one quotient bit per cycle.
module dial_div #(
    parameter int DW = 27,
    parameter int VW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          valid,
    output logic [DW-1:0] quotient
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic          busy;
        logic          valid;
        logic [CW-1:0] cnt;
        logic [VW-1:0] rem;
        logic [DW-1:0] quo;
        logic [VW-1:0] dvs;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [VW:0] trial;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        trial     = {r_q.rem, r_q.quo[DW-1]};
        if (load && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(DW - 1);
            r_d.rem  = '0;
            r_d.quo  = dividend;
            r_d.dvs  = divisor;
        end else if (r_q.busy) begin
            if (trial >= {1'b0, r_q.dvs}) begin
                r_d.rem = VW'(trial - {1'b0, r_q.dvs});
                r_d.quo = {r_q.quo[DW-2:0], 1'b1};
            end else begin
                r_d.rem = trial[VW-1:0];
                r_d.quo = {r_q.quo[DW-2:0], 1'b0};
            end
            if (r_q.cnt == '0) begin
                r_d.busy  = 1'b0;
                r_d.valid = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid    = r_q.valid;
    assign quotient = r_q.quo;
endmodule

// File: rtl/dial_clamp.sv
// Removes the guard offset and clamps to 0..limit.
module dial_clamp #(
    parameter int SW    = 13,
    parameter int CNT_W = 12
) (
    input  logic [SW-1:0]    pos,
    input  logic [SW-1:0]    guard,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] idx
);
    logic [SW-1:0] diff;

    always_comb begin
        diff = pos - guard;
        if (pos < guard)                 idx = '0;
        else if (diff > SW'(limit))      idx = limit;
        else                             idx = diff[CNT_W-1:0];
    end
endmodule

// File: rtl/dial_freq.sv
// Band base plus channel offset, in kHz.
module dial_freq #(
    parameter int CNT_W   = 12,
    parameter int START_W = 15,
    parameter int FW      = 22
) (
    input  logic               am,
    input  logic [START_W-1:0] bstart,
    input  logic [1:0]         code,
    input  logic [CNT_W-1:0]   idx,
    output logic [FW-1:0]      freq
);
    import dial_map_pkg::*;

    logic [FW-1:0] base;
    logic [FW-1:0] offs;

    always_comb begin
        base = am ? FW'(bstart) : FW'(bstart) * FW'(50);
        offs = FW'(idx) * FW'(step_khz(am, code));
        freq = base + offs;
    end
endmodule

// File: rtl/dial_mapper.sv
module dial_mapper #(
    parameter int MEAS_W  = 12,
    parameter int CNT_W   = 12,
    parameter int START_W = 15,
    parameter int GCH_W   = 9,
    parameter int GV_W    = 7,
    parameter int VOL_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               vol_mode,
    input  logic               am_band,
    input  logic [MEAS_W-1:0]  meas_x,
    input  logic [MEAS_W-1:0]  meas_y,
    input  logic [CNT_W-1:0]   chan_count,
    input  logic [START_W-1:0] band_start,
    input  logic [1:0]         spacing,
    input  logic [GCH_W-1:0]   chan_guard,
    input  logic [GV_W-1:0]    vol_guard,
    output logic               done,
    output logic               tune_req,
    output logic [CNT_W-1:0]   chan_idx,
    output logic [((START_W+6 > CNT_W+8) ? START_W+6 : CNT_W+8):0] freq_khz,
    output logic [VOL_W-1:0]   vol_code
);
    import dial_map_pkg::*;

    localparam int M1 = (CNT_W > GCH_W + 1) ? CNT_W : GCH_W + 1;
    localparam int M2 = (M1 > GV_W + 2) ? M1 : GV_W + 2;
    localparam int M3 = (M2 > VOL_W + 1) ? M2 : VOL_W + 1;
    localparam int SW = M3 + 1;
    localparam int PW = MEAS_W + SW;
    localparam int DW = PW + 2;
    localparam int VW = MEAS_W + 2;
    localparam int FW = ((START_W + 6 > CNT_W + 8) ? START_W + 6 : CNT_W + 8) + 1;
    localparam logic [CNT_W-1:0] VOL_TOP = CNT_W'((1 << VOL_W) - 1);

    typedef struct packed {
        map_state_e         st;
        logic               vmode;
        logic               am;
        logic [CNT_W-1:0]   lim;
        logic [START_W-1:0] bstart;
        logic [1:0]         sp;
        logic [SW-1:0]      grd;
        logic               done;
        logic               tune;
        logic [CNT_W-1:0]   chan;
        logic [FW-1:0]      freq;
        logic [VOL_W-1:0]   vol;
    } map_regs_t;

    map_regs_t r_d, r_q;

    logic [MEAS_W:0]  sum_w;
    logic [SW-1:0]    span;
    logic [PW-1:0]    prod;
    logic [DW-1:0]    dividend;
    logic [VW-1:0]    divisor;
    logic             accept;
    logic             div_valid;
    logic [DW-1:0]    quo;
    logic [CNT_W-1:0] idx;
    logic [FW-1:0]    freq_new;

    always_comb begin
        sum_w    = {1'b0, meas_x} + {1'b0, meas_y};
        span     = vol_mode ? SW'(1 << VOL_W) + (SW'(vol_guard) << 1)
                            : SW'(chan_count) + (SW'(chan_guard) << 1);
        prod     = PW'(meas_x) * PW'(span);
        dividend = {prod, 1'b0} + DW'(sum_w);
        divisor  = {sum_w, 1'b0};
        accept   = (r_q.st == ST_IDLE) && start && (sum_w != '0);
    end

    dial_div #(.DW(DW), .VW(VW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .dividend (dividend),
        .divisor  (divisor),
        .valid    (div_valid),
        .quotient (quo)
    );

    dial_clamp #(.SW(SW), .CNT_W(CNT_W)) u_clamp (
        .pos   (quo[SW-1:0]),
        .guard (r_q.grd),
        .limit (r_q.lim),
        .idx   (idx)
    );

    dial_freq #(.CNT_W(CNT_W), .START_W(START_W), .FW(FW)) u_freq (
        .am     (r_q.am),
        .bstart (r_q.bstart),
        .code   (r_q.sp),
        .idx    (idx),
        .freq   (freq_new)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tune = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st     = ST_WAIT;
                    r_d.vmode  = vol_mode;
                    r_d.am     = am_band;
                    r_d.lim    = vol_mode ? VOL_TOP : chan_count;
                    r_d.bstart = band_start;
                    r_d.sp     = spacing;
                    r_d.grd    = vol_mode ? SW'(vol_guard) : SW'(chan_guard);
                end
            end
            ST_WAIT: begin
                if (div_valid) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.vmode) begin
                        r_d.vol = idx[VOL_W-1:0];
                    end else begin
                        r_d.chan = idx;
                        r_d.freq = freq_new;
                        r_d.tune = (idx != r_q.chan);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.vol <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign tune_req = r_q.tune;
    assign chan_idx = r_q.chan;
    assign freq_khz = r_q.freq;
    assign vol_code = r_q.vol;
endmodule

// File: rtl/dial_mapper_chk.sv
module dial_mapper_chk #(
    parameter int CNT_W = 12,
    parameter int FW    = 22,
    parameter int VOL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             tune_req,
    input logic [CNT_W-1:0] chan_idx,
    input logic [FW-1:0]    freq_khz,
    input logic [VOL_W-1:0] vol_code
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R6
    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(chan_idx) && $stable(freq_khz)));              // R6
    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(vol_code));                                     // R5
    AST_TUNE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tune_req |-> done);                                               // R8
    AST_TUNE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        tune_req |-> (chan_idx != $past(chan_idx)));                      // R8
    AST_MOVE_GIVES_TUNE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_idx != $past(chan_idx)) |-> tune_req);                      // R8
endmodule

bind dial_mapper dial_mapper_chk #(.CNT_W(CNT_W), .FW(FW), .VOL_W(VOL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .tune_req (tune_req),
    .chan_idx (chan_idx),
    .freq_khz (freq_khz),
    .vol_code (vol_code)
);

// File: tb/tb_dial_mapper.sv
`timescale 1ns/1ps
module tb_dial_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        vol_mode = 1'b0;
    logic        am_band = 1'b0;
    logic [11:0] meas_x = '0;
    logic [11:0] meas_y = '0;
    logic [11:0] chan_count = 12'd100;
    logic [14:0] band_start = 15'd1760;
    logic [1:0]  spacing = 2'b01;
    logic [8:0]  chan_guard = 9'd10;
    logic [6:0]  vol_guard = 7'd4;
    logic        done, tune_req;
    logic [11:0] chan_idx;
    logic [21:0] freq_khz;
    logic [4:0]  vol_code;

    int n_chk = 0;
    int n_bad = 0;
    int prev_chan = 0;
    int lat;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dial_mapper dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vol_mode(vol_mode),
        .am_band(am_band), .meas_x(meas_x), .meas_y(meas_y),
        .chan_count(chan_count), .band_start(band_start), .spacing(spacing),
        .chan_guard(chan_guard), .vol_guard(vol_guard), .done(done),
        .tune_req(tune_req), .chan_idx(chan_idx), .freq_khz(freq_khz),
        .vol_code(vol_code)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int map_pos(input int x, input int y, input int n, input int g, input int base);
        longint s, q;
        s = base + 2 * g;
        q = (2 * longint'(x) * s + x + y) / (2 * longint'(x + y));
        if (q < g) return 0;
        if (q - g > n) return n;
        return int'(q - g);
    endfunction

    function automatic int step_of(input bit am, input int code);
        if (am) return (code == 0) ? 1 : (code == 1) ? 9 : 10;
        return (code == 0) ? 200 : (code == 1) ? 100 : 50;
    endfunction

    // pulse start, then count edges until done is seen
    task automatic convert(output int cycles);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 0;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run_chan(input string req, input int x, input int y);
        int e, ef;
        meas_x = 12'(x); meas_y = 12'(y); vol_mode = 1'b0;
        convert(lat);
        e  = map_pos(x, y, chan_count, chan_guard, chan_count);
        ef = (am_band ? band_start : band_start * 50) + e * step_of(am_band, spacing);
        chk(req, "done", done, 1);
        chk(req, "chan_idx", chan_idx, e);
        chk("R4", "freq_khz", freq_khz, ef);
        chk("R8", "tune_req", tune_req, (e != prev_chan));
        prev_chan = e;
        @(negedge clk);
        chk("R6", "done drops", done, 0);
    endtask

    task automatic t_reset();
        chk("R1", "done", done, 0);
        chk("R1", "tune_req", tune_req, 0);
        chk("R1", "chan_idx", chan_idx, 0);
        chk("R1", "freq_khz", freq_khz, 0);
        chk("R1", "vol_code", vol_code, 31);
    endtask

    task automatic t_mid();
        am_band = 0; band_start = 1760; spacing = 2'b01; chan_count = 100; chan_guard = 10;
        run_chan("R2", 1000, 1000);
        chk("R6", "latency", lat, 28);
        chk("R2", "centre value", chan_idx, 50);
        chk("R4", "centre freq", freq_khz, 93000);
    endtask

    task automatic t_guard();
        run_chan("R3", 10, 4000);
        chk("R3", "low clamp", chan_idx, 0);
        run_chan("R3", 4000, 5);
        chk("R3", "high clamp", chan_idx, 100);
        run_chan("R8", 4000, 5);   // same channel: no retune
        chk("R8", "repeat no tune", tune_req, 0);
    endtask

    task automatic t_round();
        chan_count = 8; chan_guard = 1; spacing = 2'b00;
        run_chan("R2", 1, 3);      // 2.5 rounds up to 3, minus guard = 2
        chk("R2", "half up", chan_idx, 2);
        chk("R4", "fm 200k", freq_khz, 88400);
        spacing = 2'b10;
        run_chan("R2", 1, 4);      // exact 2, minus guard = 1
        chk("R4", "fm 50k", freq_khz, 88050);
        spacing = 2'b11;
        run_chan("R2", 3, 1);
    endtask

    task automatic t_am();
        am_band = 1; band_start = 530; chan_count = 117; chan_guard = 0; spacing = 2'b10;
        run_chan("R4", 500, 500);
        chk("R4", "am 10k", freq_khz, 1120);
        spacing = 2'b01;
        run_chan("R4", 700, 1300);
        spacing = 2'b00;
        run_chan("R4", 1234, 777);
        am_band = 0; band_start = 1760; chan_count = 100; chan_guard = 10; spacing = 2'b01;
    endtask

    task automatic t_vol();
        int keep_c, keep_f;
        keep_c = chan_idx; keep_f = freq_khz;
        vol_mode = 1; vol_guard = 4;
        meas_x = 700; meas_y = 700;
        convert(lat);
        chk("R5", "done", done, 1);
        chk("R5", "vol mid", vol_code, map_pos(700, 700, 31, 4, 32));
        chk("R5", "vol mid value", vol_code, 16);
        chk("R8", "no tune in vol", tune_req, 0);
        chk("R5", "chan untouched", chan_idx, keep_c);
        chk("R5", "freq untouched", freq_khz, keep_f);
        meas_x = 4000; meas_y = 1;
        convert(lat);
        chk("R5", "vol top clamp", vol_code, 31);
        meas_x = 2; meas_y = 4000;
        convert(lat);
        chk("R5", "vol bottom clamp", vol_code, 0);
        vol_mode = 0;
    endtask

    task automatic t_zero();
        int seen = 0;
        int keep_c, keep_v, keep_f;
        keep_c = chan_idx; keep_v = vol_code; keep_f = freq_khz;
        meas_x = 0; meas_y = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R7", "no done", seen, 0);
        chk("R7", "chan kept", chan_idx, keep_c);
        chk("R7", "freq kept", freq_khz, keep_f);
        chk("R7", "vol kept", vol_code, keep_v);
    endtask

    task automatic t_busy();
        int seen = 0;
        int e;
        vol_mode = 0; meas_x = 300; meas_y = 900;
        e = map_pos(300, 900, 100, 10, 100);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        meas_x = 3000; meas_y = 10;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (done) begin
                seen++;
                chk("R9", "first inputs used", chan_idx, e);
            end
        end
        chk("R9", "single done", seen, 1);
        prev_chan = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mid();
        t_guard();
        t_round();
        t_am();
        t_vol();
        t_zero();
        t_busy();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule